// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a core's register file and a data memory that is one word wide. It takes a base register value and a signed 16-bit displacement and adds them to form the byte address. For stores it produces a word-aligned memory address, per-byte write enables and write data in which the narrow operand is copied across the lanes. For loads it picks the addressed byte or halfword out of the word that memory returns and widens it to the full data width. Software chooses sign or zero extension.

Lanes are numbered big-endian: the byte at the lowest address within a word is the most significant byte. The request is registered once. The memory strobe, address, enables and write data appear in the cycle after the request. The memory answers a load within that same cycle, and the aligned load result is valid then. An access that breaks its natural alignment raises an error flag and does not reach memory.

Top module: `lsa_align_unit`

## Requirements
- R1: The effective address is `base` plus `offset` sign-extended to 32 bits, with wrap-around. In the cycle after `req_valid`, `mem_addr` carries that address with its two low bits cleared.
- R2: `req_size` encodes 0 = byte, 1 = halfword, 2 = word. Code 3 is reserved and is always reported as misaligned.
- R3: A halfword needs address bit 0 clear, and a word needs address bits 1..0 clear. A misaligned request sets `misalign_err` in the next cycle and holds `mem_req`, `mem_we` and `mem_be` at zero in that cycle.
- R4: `mem_be[i]` enables data bits 8i+7..8i. A byte store at low address bits k sets only bit 3-k. A halfword store sets 1100 at offset 0 and 0011 at offset 2. A word store sets 1111. A load, an idle cycle or an error gives 0000.
- R5: Store data carries the low byte of `st_src` in all four lanes for a byte and the low halfword in both halves for a halfword. A word is passed through unchanged.
- R6: Load lane selection is big-endian. A byte at offset k comes from bits 31-8k..24-8k. A halfword at offset 0 comes from bits 31..16, and at offset 2 from bits 15..0. `ld_data` reflects `mem_rdata` in the cycle after the request.
- R7: A signed byte or halfword load copies the selected sign bit into all upper bits of `ld_data`.
- R8: An unsigned byte or halfword load fills the upper bits of `ld_data` with zeros. `req_signed` has no effect on a word load.
- R9: A valid, aligned request raises `mem_req` for exactly the next cycle, and `mem_we` as well when it is a store. After reset, `mem_req`, `mem_we`, `mem_be` and `misalign_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed | input | 1 | Sign-extend sub-word load data |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| st_src | input | 32 | Store source register value |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Word returned by memory |
| ld_data | output | 32 | Aligned, extended load result |
| misalign_err | output | 1 | Misaligned or reserved-size access |

## Verification
The embedded properties are checked on every cycle. They cover the shape of the enable pattern for each size, that no enable or strobe appears alongside an error, and that the strobe address is word aligned. They also cover that sub-word load results have upper bits that agree with the extension mode. Only the bench scenarios can show that the lane chosen for each offset is the correct one under big-endian numbering. The same holds for the displacement sign handling, and for a store of one width being read back correctly through loads of another width and signedness.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
   typedef enum logic [1:0] {
      ACC_BYTE = 2'd0,
      ACC_HALF = 2'd1,
      ACC_WORD = 2'd2,
      ACC_RSVD = 2'd3
   } acc_size_e;
endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen
   import lsa_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 16,
   parameter int LANE_W = 2
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFS_W-1:0]  offset,
   input  acc_size_e         size,
   output logic [ADDR_W-1:0] ea,
   output logic [LANE_W-1:0] lane,
   output logic              misaligned
);
   localparam int EXT_W = ADDR_W - OFS_W;

   if (OFS_W > ADDR_W) begin : g_bad_ofs
      $error("lsa_addr_gen: OFS_W wider than ADDR_W");
   end

   logic [ADDR_W-1:0] ofs_ext;
   assign ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};
   assign ea      = base + ofs_ext;
   assign lane    = ea[LANE_W-1:0];

   always_comb begin
      unique case (size)
         ACC_BYTE: misaligned = 1'b0;
         ACC_HALF: misaligned = lane[0];
         ACC_WORD: misaligned = |lane;
         default:  misaligned = 1'b1;
      endcase
   end
endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
   import lsa_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANE_W = $clog2(DATA_W / 8)
) (
   input  acc_size_e          size,
   input  logic [LANE_W-1:0]  lane,
   input  logic [DATA_W-1:0]  src,
   output logic [DATA_W/8-1:0] be,
   output logic [DATA_W-1:0]  wdata
);
   localparam int NUM_LANES = DATA_W / 8;

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      localparam int K = NUM_LANES - 1 - i;
      localparam logic [LANE_W-1:0] KL = LANE_W'(K);
      always_comb begin
         unique case (size)
            ACC_BYTE: begin
               be[i]            = (lane == KL);
               wdata[8*i +: 8]  = src[7:0];
            end
            ACC_HALF: begin
               be[i]            = (lane[LANE_W-1:1] == KL[LANE_W-1:1]);
               wdata[8*i +: 8]  = (K % 2 == 0) ? src[15:8] : src[7:0];
            end
            ACC_WORD: begin
               be[i]            = 1'b1;
               wdata[8*i +: 8]  = src[8*i +: 8];
            end
            default: begin
               be[i]            = 1'b0;
               wdata[8*i +: 8]  = src[8*i +: 8];
            end
         endcase
      end
   end
endmodule

// File: rtl/lsa_load_lane.sv
module lsa_load_lane
   import lsa_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANE_W = $clog2(DATA_W / 8)
) (
   input  acc_size_e         size,
   input  logic [LANE_W-1:0] lane,
   input  logic              sgn,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] data
);
   localparam int NUM_LANES = DATA_W / 8;
   localparam int NUM_HALF  = NUM_LANES / 2;

   logic [7:0]  byte_at [NUM_LANES];
   logic [15:0] half_at [NUM_HALF];

   for (genvar k = 0; k < NUM_LANES; k++) begin : g_byte
      assign byte_at[k] = rdata[DATA_W-1-8*k -: 8];
   end
   for (genvar j = 0; j < NUM_HALF; j++) begin : g_half
      assign half_at[j] = rdata[DATA_W-1-16*j -: 16];
   end

   logic [7:0]  sel_b;
   logic [15:0] sel_h;
   assign sel_b = byte_at[lane];
   assign sel_h = half_at[lane[LANE_W-1:1]];

   always_comb begin
      unique case (size)
         ACC_BYTE: data = {{(DATA_W-8){sgn & sel_b[7]}}, sel_b};
         ACC_HALF: data = {{(DATA_W-16){sgn & sel_h[15]}}, sel_h};
         default:  data = rdata;
      endcase
   end
endmodule

// File: rtl/lsa_align_unit.sv
module lsa_align_unit
   import lsa_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int OFS_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [1:0]          req_size,
   input  logic                req_signed,
   input  logic [ADDR_W-1:0]   base,
   input  logic [OFS_W-1:0]    offset,
   input  logic [DATA_W-1:0]   st_src,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic [DATA_W-1:0]   ld_data,
   output logic                misalign_err
);
   localparam int NUM_LANES = DATA_W / 8;
   localparam int LANE_W    = $clog2(NUM_LANES);

   if (DATA_W < 32 || DATA_W % 16 != 0) begin : g_bad_data
      $error("lsa_align_unit: DATA_W must be a multiple of 16, at least 32");
   end
   if (ADDR_W <= LANE_W) begin : g_bad_addr
      $error("lsa_align_unit: ADDR_W too narrow");
   end

   acc_size_e         size_in;
   logic [ADDR_W-1:0] ea;
   logic [LANE_W-1:0] lane;
   logic              mis;
   logic [NUM_LANES-1:0] be_c;
   logic [DATA_W-1:0] wdata_c;

   assign size_in = acc_size_e'(req_size);

   lsa_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .LANE_W(LANE_W)) i_addr (
      .base(base), .offset(offset), .size(size_in),
      .ea(ea), .lane(lane), .misaligned(mis)
   );

   lsa_store_lane #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_st (
      .size(size_in), .lane(lane), .src(st_src),
      .be(be_c), .wdata(wdata_c)
   );

   logic              go;
   acc_size_e         ld_size_q;
   logic [LANE_W-1:0] ld_lane_q;
   logic              ld_sgn_q;

   assign go = req_valid & ~mis;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req      <= 1'b0;
         mem_we       <= 1'b0;
         mem_addr     <= '0;
         mem_be       <= '0;
         mem_wdata    <= '0;
         misalign_err <= 1'b0;
         ld_size_q    <= ACC_WORD;
         ld_lane_q    <= '0;
         ld_sgn_q     <= 1'b0;
      end else begin
         mem_req      <= go;
         mem_we       <= go & req_write;
         mem_be       <= (go & req_write) ? be_c : '0;
         misalign_err <= req_valid & mis;
         if (req_valid) begin
            mem_addr  <= {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
            mem_wdata <= wdata_c;
            ld_size_q <= size_in;
            ld_lane_q <= lane;
            ld_sgn_q  <= req_signed;
         end
      end
   end

   lsa_load_lane #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_ld (
      .size(ld_size_q), .lane(ld_lane_q), .sgn(ld_sgn_q),
      .rdata(mem_rdata), .data(ld_data)
   );

   AST_ERR_BLOCKS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_err |-> (!mem_req && !mem_we && mem_be == '0)); // R3
   AST_BE_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_be != '0) |-> mem_we); // R4
   AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                  $countones(mem_be) == NUM_LANES)); // R4
   AST_WE_IMPLIES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req); // R9
   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[LANE_W-1:0] == '0)); // R1
   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !mem_req); // R9
   AST_SEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_size_q == ACC_BYTE && ld_sgn_q) |->
         (ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}})); // R7
   AST_ZEXT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_size_q == ACC_HALF && !ld_sgn_q) |->
         (ld_data[DATA_W-1:16] == '0)); // R8
endmodule

// File: tb/test_lsa_align_unit.sv
module test_lsa_align_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [31:0] base = '0, st_src = '0;
   logic [15:0] offset = '0;
   logic        mem_req, mem_we, misalign_err;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, ld_data;
   logic [3:0]  mem_be;

   int total = 0, bad = 0, cycles = 0;
   logic [31:0] bus_mem [16];
   logic [31:0] ref_mem [16];

   always #10 clk = ~clk;

   lsa_align_unit i_lsa_align_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_signed(req_signed), .base(base), .offset(offset),
      .st_src(st_src), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .ld_data(ld_data), .misalign_err(misalign_err)
   );

   assign mem_rdata = bus_mem[mem_addr[5:2]];

   always @(posedge clk) begin
      if (mem_we) begin
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) bus_mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Behavioural reference: one access, checked one cycle later.
   task automatic access(input bit wr, input int sz, input bit sg,
                         input logic [31:0] b, input logic [15:0] o,
                         input logic [31:0] src);
      logic [31:0] ea, w, exp_ld, exp_wd;
      logic [3:0]  exp_be;
      bit mis;
      int off, idx;
      ea  = b + {{16{o[15]}}, o};
      off = int'(ea[1:0]);
      idx = int'(ea[5:2]);
      mis = (sz == 3) || (sz == 1 && off % 2 != 0) || (sz == 2 && off != 0);
      exp_be = 4'b0000;
      exp_wd = src;
      if (sz == 0) begin
         exp_be = 4'b0001 << (3 - off);
         exp_wd = {4{src[7:0]}};
      end else if (sz == 1) begin
         exp_be = (off < 2) ? 4'b1100 : 4'b0011;
         exp_wd = {2{src[15:0]}};
      end else if (sz == 2) begin
         exp_be = 4'b1111;
      end
      w = ref_mem[idx];
      if (sz == 0) begin
         exp_ld = (w >> (8 * (3 - off))) & 32'hFF;
         if (sg && exp_ld[7]) exp_ld = exp_ld - 32'h100;
      end else if (sz == 1) begin
         exp_ld = (w >> (16 * (1 - off / 2))) & 32'hFFFF;
         if (sg && exp_ld[15]) exp_ld = exp_ld - 32'h10000;
      end else begin
         exp_ld = w;
      end
      req_valid = 1'b1; req_write = wr; req_size = 2'(sz); req_signed = sg;
      base = b; offset = o; st_src = src;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R3", "misalign_err", {31'd0, misalign_err}, {31'd0, mis});
      chk("R9", "mem_req", {31'd0, mem_req}, {31'd0, !mis});
      chk("R9", "mem_we", {31'd0, mem_we}, {31'd0, !mis && wr});
      chk("R4", "mem_be", {28'd0, mem_be}, (!mis && wr) ? {28'd0, exp_be} : 32'd0);
      if (!mis) begin
         chk("R1", "mem_addr", mem_addr, {ea[31:2], 2'b00});
         if (wr) chk("R5", "mem_wdata", mem_wdata, exp_wd);
         else    chk("R6 R7 R8", "ld_data", ld_data, exp_ld);
         if (wr)
            for (int k = 0; k < 4; k++)
               if (exp_be[k]) ref_mem[idx][8*k +: 8] = exp_wd[8*k +: 8];
      end
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin
         bus_mem[i] = (32'(i) * 32'h1357_9BDF) ^ 32'h8C40_7F81;
         ref_mem[i] = (32'(i) * 32'h1357_9BDF) ^ 32'h8C40_7F81;
      end
      repeat (2) @(negedge clk);
      chk("R9", "reset mem_req", {31'd0, mem_req}, 32'd0);
      chk("R9", "reset mem_we", {31'd0, mem_we}, 32'd0);
      chk("R9", "reset mem_be", {28'd0, mem_be}, 32'd0);
      chk("R9", "reset misalign_err", {31'd0, misalign_err}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 R1: word store and read-back
      access(1, 2, 0, 32'h10, 16'h0, 32'h1122_3344);
      access(0, 2, 1, 32'h10, 16'h0, 0);
      // R6 R7 R8: every byte offset, both extension modes
      for (int k = 0; k < 4; k++) begin
         access(0, 0, 1, 32'h10, 16'(k), 0);
         access(0, 0, 0, 32'h10, 16'(k), 0);
      end
      // R1: negative displacement, byte store to 0x21
      access(1, 0, 0, 32'h30, 16'hFFF1, 32'h1234_56A5);
      access(1, 1, 0, 32'h20, 16'h2, 32'hDEAD_8001);
      access(0, 2, 0, 32'h20, 16'h0, 0);
      for (int k = 0; k < 4; k += 2) begin
         access(0, 1, 1, 32'h24, 16'(k - 4), 0);
         access(0, 1, 0, 32'h24, 16'(k - 4), 0);
      end
      // R6 R7 on seeded words with top bits set
      for (int k = 0; k < 4; k++) access(0, 0, 1, 32'h34, 16'(k), 0);
      access(0, 1, 1, 32'h8, 16'h0, 0);
      access(0, 1, 0, 32'h8, 16'h2, 0);
      // R2 R3: misaligned and reserved
      access(0, 1, 0, 32'h10, 16'h1, 0);
      access(1, 1, 0, 32'h10, 16'h3, 32'hFFFF_FFFF);
      access(1, 2, 0, 32'h12, 16'h0, 32'hFFFF_FFFF);
      access(0, 2, 0, 32'h11, 16'h0, 0);
      access(1, 3, 0, 32'h10, 16'h0, 32'h0BAD_0BAD);
      access(0, 3, 0, 32'h14, 16'h0, 0);
      // R3: the suppressed stores left memory untouched
      access(0, 2, 0, 32'h10, 16'h0, 0);
      // R4 R5: byte stores on every lane, then R8 word load ignores sign
      for (int k = 0; k < 4; k++) access(1, 0, 0, 32'h3C, 16'(k), 32'(8'hF0 + k));
      access(0, 2, 1, 32'h3C, 16'h0, 0);
      // R9: idle cycle yields no strobe
      @(posedge clk); @(negedge clk);
      chk("R9", "idle mem_req", {31'd0, mem_req}, 32'd0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected<=20000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule